// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the raster timing for a video output. A horizontal counter walks across each line and a vertical counter steps once per line. From these two positions the block derives an active-video qualifier, horizontal and vertical sync pulses, a sync-on-green indication, a fetch request that fires at a programmable point in every line, and frame status (a frame-start pulse and a vertical-blank level).

Every position is programmed through a simple write port. Each position is written as the last count it covers, so a line of N pixels has an extent of N-1. The geometry and prefetch registers are shadowed. They reach the counters only at the boundary between two frames, or at any time while the generator is stopped, so a frame in progress always finishes with the geometry it began with. The control, sync-control and display-control registers act on the next clock. Power-management blanking uses these registers: software inverts a sync, drops one sync or both, and forces the active video off.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low, every register clears. `h_pos` and `v_pos` read 0 and every output is low.
- R2: While control bit 0 (run) is set, `h_pos` counts 0 up to the horizontal extent and then wraps to 0. `v_pos` advances by one at each horizontal wrap and returns to 0 after the vertical extent. While run is clear, both counters are held at 0.
- R3: The write address map is: 0 control, 1 horizontal extent, 2 horizontal display end, 3 hsync first count, 4 hsync last count, 5 vertical extent, 6 vertical display end, 7 vsync first count, 8 vsync last count, 9 fetch point, 10 sync control, 11 display control. Addresses 1 to 9 load shadow copies. The counters use a shadow value only from the clock edge that follows the last pixel of a frame, or from the edge after any cycle in which run is clear. Addresses 0, 10 and 11 act from the next edge.
- R4: `de` is high only when run is set, control bit 1 (refresh) is set, display-control bit 1 (display off) is clear, `h_pos` is at or below the horizontal display end, and `v_pos` is at or below the vertical display end.
- R5: While running, the internal horizontal sync is active for `h_pos` from the hsync first count to the hsync last count, both counts included. The vertical sync follows the same rule on `v_pos`. Both syncs are active high before inversion.
- R6: Sync-control bit 3 inverts `hsync` and bit 4 inverts `vsync`. The idle level of each sync output equals its inversion bit.
- R7: Sync-control bit 5 holds `hsync` at its idle level. Bit 6 does the same for `vsync`. Bit 1 holds both syncs idle.
- R8: `green_sync` is high when sync-control bit 0 is set and at least one sync that is not suppressed is active.
- R9: `fetch_req` is high for the one cycle in which `h_pos` equals the fetch point. This happens on every line while run and refresh are both set.
- R10: `frame_start` is high while running with both counters at 0. `vblank` is high while running with `v_pos` above the vertical display end.
- R11: Writes to addresses 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| h_pos | output | CW | Horizontal count |
| v_pos | output | CW | Vertical count |
| de | output | 1 | Active video qualifier |
| hsync | output | 1 | Horizontal sync after polarity and suppression |
| vsync | output | 1 | Vertical sync after polarity and suppression |
| green_sync | output | 1 | Composite sync for the green channel |
| fetch_req | output | 1 | Per-line fetch request pulse |
| frame_start | output | 1 | First pixel of a frame |
| vblank | output | 1 | Vertical blanking interval |

## Verification
Some properties are checked by the assertions on every cycle. The counters stay inside their extents and sit at 0 while stopped. The live geometry never changes except at a load point. A suppressed sync sits at its idle level. No active video appears during vertical blank. The fetch pulse lasts one cycle. Other behaviour can only be shown by the bench scenarios against its reference model. These scenarios cover the exact sync windows, the effect of an inverted idle level, the frame-boundary timing of a geometry rewrite issued mid-frame, the sync-on-green merge, and the fact that unmapped addresses change nothing.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   // indices into the shadowed geometry vector (address = index + 1)
   localparam int NTIM    = 9;
   localparam int T_HEXT  = 0;
   localparam int T_HDISP = 1;
   localparam int T_HSB   = 2;
   localparam int T_HSE   = 3;
   localparam int T_VEXT  = 4;
   localparam int T_VDISP = 5;
   localparam int T_VSB   = 6;
   localparam int T_VSE   = 7;
   localparam int T_FETCH = 8;
   // immediate registers
   localparam int A_CTRL  = 0;
   localparam int A_SYNC  = 10;
   localparam int A_DISP  = 11;
   // control bits
   localparam int C_RUN     = 0;
   localparam int C_REFRESH = 1;
   // compacted sync-control vector
   localparam int K_GREEN  = 0;
   localparam int K_ALLOFF = 1;
   localparam int K_HINV   = 2;
   localparam int K_VINV   = 3;
   localparam int K_HOFF   = 4;
   localparam int K_VOFF   = 5;
   localparam int KW       = 6;
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
   import rtg_pkg::*;
#(
   parameter int CW = 12,
   parameter int AW = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [CW-1:0]              wr_data,
   input  logic                       frame_end,
   output logic [NTIM-1:0][CW-1:0]    tim,
   output logic [1:0]                 ctrl,
   output logic [KW-1:0]              sctl,
   output logic                       doff
);
   logic [NTIM-1:0][CW-1:0] shadow;
   logic                    load;

   assign load = !ctrl[C_RUN] || frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         tim    <= '0;
         ctrl   <= '0;
         sctl   <= '0;
         doff   <= 1'b0;
      end else begin
         if (load) tim <= shadow;
         if (wr_en) begin
            for (int i = 0; i < NTIM; i++)
               if (wr_addr == AW'(i + 1)) shadow[i] <= wr_data;
            if (wr_addr == AW'(A_CTRL)) ctrl <= wr_data[1:0];
            if (wr_addr == AW'(A_SYNC))
               sctl <= {wr_data[6], wr_data[5], wr_data[4],
                        wr_data[3], wr_data[1], wr_data[0]};
            if (wr_addr == AW'(A_DISP)) doff <= wr_data[1];
         end
      end
   end

   // R3: live geometry only moves at a load point
   a_r3_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(tim));
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] h_ext,
   input  logic [CW-1:0] v_ext,
   output logic [CW-1:0] h,
   output logic [CW-1:0] v,
   output logic          frame_end
);
   assign frame_end = run && (h == h_ext) && (v == v_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h <= '0;
         v <= '0;
      end else if (!run) begin
         h <= '0;
         v <= '0;
      end else if (h == h_ext) begin
         h <= '0;
         v <= (v == v_ext) ? '0 : v + 1'b1;
      end else begin
         h <= h + 1'b1;
      end
   end

   a_r2_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (h <= h_ext) && (v <= v_ext));
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (h == '0) && (v == '0));
endmodule

// File: rtl/rtg_sync.sv
module rtg_sync #(
   parameter int CW = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [1:0][CW-1:0]  pos,
   input  logic [1:0][CW-1:0]  first,
   input  logic [1:0][CW-1:0]  last,
   input  logic [1:0]          inv,
   input  logic [1:0]          sup,
   output logic [1:0]          level,
   output logic [1:0]          pulse
);
   // axis 0 = horizontal, axis 1 = vertical
   for (genvar a = 0; a < 2; a++) begin : g_axis
      logic raw;
      assign raw      = run && (pos[a] >= first[a]) && (pos[a] <= last[a]);
      assign pulse[a] = raw && !sup[a];
      assign level[a] = pulse[a] ^ inv[a];

      // R7: a suppressed sync sits at its idle level
      a_r7_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
         sup[a] |-> level[a] == inv[a]);
   end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int CW = 12,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] h_pos,
   output logic [CW-1:0] v_pos,
   output logic          de,
   output logic          hsync,
   output logic          vsync,
   output logic          green_sync,
   output logic          fetch_req,
   output logic          frame_start,
   output logic          vblank
);
   if (CW < 7) begin : g_bad_cw
      $error("raster_timing_gen: CW must be at least 7");
   end
   if (AW < 4) begin : g_bad_aw
      $error("raster_timing_gen: AW must be at least 4");
   end

   logic [NTIM-1:0][CW-1:0] tim;
   logic [1:0]              ctrl;
   logic [KW-1:0]           sctl;
   logic                    doff, frame_end, run, refresh;
   logic [1:0][CW-1:0]      pos, first, last;
   logic [1:0]              inv, sup, level, pulse;

   rtg_regfile #(.CW(CW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_end(frame_end), .tim(tim), .ctrl(ctrl),
      .sctl(sctl), .doff(doff));

   assign run     = ctrl[C_RUN];
   assign refresh = ctrl[C_REFRESH];

   rtg_counters #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .h_ext(tim[T_HEXT]),
      .v_ext(tim[T_VEXT]), .h(h_pos), .v(v_pos), .frame_end(frame_end));

   assign pos   = {v_pos, h_pos};
   assign first = {tim[T_VSB], tim[T_HSB]};
   assign last  = {tim[T_VSE], tim[T_HSE]};
   assign inv   = {sctl[K_VINV], sctl[K_HINV]};
   assign sup   = {sctl[K_VOFF] | sctl[K_ALLOFF], sctl[K_HOFF] | sctl[K_ALLOFF]};

   rtg_sync #(.CW(CW)) u_sync (
      .clk(clk), .rst_n(rst_n), .run(run), .pos(pos), .first(first),
      .last(last), .inv(inv), .sup(sup), .level(level), .pulse(pulse));

   assign hsync       = level[0];
   assign vsync       = level[1];
   assign green_sync  = sctl[K_GREEN] && (|pulse);
   assign de          = run && refresh && !doff &&
                        (h_pos <= tim[T_HDISP]) && (v_pos <= tim[T_VDISP]);
   assign fetch_req   = run && refresh && (h_pos == tim[T_FETCH]);
   assign frame_start = run && (h_pos == '0) && (v_pos == '0);
   assign vblank      = run && (v_pos > tim[T_VDISP]);

   // R10: no active video inside vertical blank
   a_r10_blank_no_de: assert property (@(posedge clk) disable iff (!rst_n)
      vblank |-> !de);
   // R10: a frame never starts inside vertical blank
   a_r10_start_visible: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !vblank);
   // R9: the fetch request is a single-cycle pulse within a frame
   a_r9_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !frame_end && (tim[T_HEXT] != '0) |=> !fetch_req);
endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
   localparam int CW = 12;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] h_pos, v_pos;
   logic          de, hsync, vsync, green_sync, fetch_req, frame_start, vblank;

   raster_timing_gen #(.CW(CW), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .h_pos(h_pos), .v_pos(v_pos), .de(de),
      .hsync(hsync), .vsync(vsync), .green_sync(green_sync),
      .fetch_req(fetch_req), .frame_start(frame_start), .vblank(vblank));

   always #2 clk = ~clk;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    armed = 0;
   bit    done  = 0;
   string phase = "R1";
   string stag  = "R5";

   // reference model state
   int m_ctrl, m_sctl, m_doff, mh, mv;
   int sh [9];
   int ac [9];

   always @(posedge clk or negedge rst_n) begin : model
      int nh, nv;
      bit ld, run;
      if (!rst_n) begin
         m_ctrl = 0; m_sctl = 0; m_doff = 0; mh = 0; mv = 0;
         for (int k = 0; k < 9; k++) begin sh[k] = 0; ac[k] = 0; end
      end else begin
         run = (m_ctrl & 1) != 0;
         ld  = !run || (mh == ac[0] && mv == ac[4]);
         if (!run) begin nh = 0; nv = 0; end
         else if (mh == ac[0]) begin nh = 0; nv = (mv == ac[4]) ? 0 : mv + 1; end
         else begin nh = mh + 1; nv = mv; end
         if (ld) for (int k = 0; k < 9; k++) ac[k] = sh[k];
         if (wr_en) begin
            case (int'(wr_addr))
               0:  m_ctrl = int'(wr_data) & 3;
               1, 2, 3, 4, 5, 6, 7, 8, 9: sh[int'(wr_addr) - 1] = int'(wr_data);
               10: m_sctl = int'(wr_data) & 'h7f;
               11: m_doff = (int'(wr_data) >> 1) & 1;
               default: ;
            endcase
         end
         mh = nh; mv = nv;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s (phase %s): got %0d expected %0d", req, what, phase, act, exp);
      end
   endtask

   always @(negedge clk) begin : compare
      bit run, rfr, hr, vr, hsup, vsup, hp, vp;
      if (armed && !done) begin
         run  = (m_ctrl & 1) != 0;
         rfr  = (m_ctrl & 2) != 0;
         hsup = (m_sctl & 'h22) != 0;
         vsup = (m_sctl & 'h42) != 0;
         hr   = run && mh >= ac[2] && mh <= ac[3];
         vr   = run && mv >= ac[6] && mv <= ac[7];
         hp   = hr && !hsup;
         vp   = vr && !vsup;
         chk("R2", "h_pos", int'(h_pos), mh);
         chk("R2", "v_pos", int'(v_pos), mv);
         chk("R4", "de", int'(de),
             int'(run && rfr && m_doff == 0 && mh <= ac[1] && mv <= ac[5]));
         chk(stag, "hsync", int'(hsync), int'(hp ^ ((m_sctl & 'h08) != 0)));
         chk(stag, "vsync", int'(vsync), int'(vp ^ ((m_sctl & 'h10) != 0)));
         chk("R8", "green_sync", int'(green_sync), int'(((m_sctl & 1) != 0) && (hp || vp)));
         chk("R9", "fetch_req", int'(fetch_req), int'(run && rfr && mh == ac[8]));
         chk("R10", "frame_start", int'(frame_start), int'(run && mh == 0 && mv == 0));
         chk("R10", "vblank", int'(vblank), int'(run && mv > ac[5]));
      end
   end

   task automatic wr(int a, int d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : stim
      // R1: reset state checked by the per-cycle compare
      @(posedge clk); #1;
      armed = 1;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R3: program geometry while stopped (line 20, frame 10 lines)
      phase = "R3";
      wr(1, 19); wr(2, 11); wr(3, 13); wr(4, 15);
      wr(5, 9);  wr(6, 5);  wr(7, 6);  wr(8, 7);
      wr(9, 16);
      idle(3);
      // R2: run with refresh on
      phase = "R2";
      wr(0, 3);
      idle(450);

      // R3: rewrite geometry mid-frame, takes effect at the frame boundary
      phase = "R3";
      idle(37);
      wr(1, 15); wr(2, 9); wr(3, 10); wr(4, 12);
      wr(5, 7);  wr(6, 4); wr(7, 5);  wr(8, 6); wr(9, 0);
      idle(400);

      // R6: invert both syncs
      stag = "R6"; phase = "R6";
      wr(10, 'h18);
      idle(260);
      // R7: drop hsync only, inverted vsync kept
      stag = "R7"; phase = "R7";
      wr(10, 'h30);
      idle(260);
      // R7: drop vsync only
      wr(10, 'h48);
      idle(260);
      // R7 and R4: power-down style, all sync off and display off
      wr(10, 'h02); wr(11, 2);
      idle(260);
      // R4: unblank
      phase = "R4";
      wr(11, 0);
      idle(200);
      // R8: sync on green with both syncs live
      stag = "R5"; phase = "R8";
      wr(10, 'h01);
      idle(260);
      // R8: green merge with hsync suppressed
      wr(10, 'h21);
      idle(200);
      // R9 and R4: refresh off silences de and fetch
      phase = "R9";
      wr(0, 1);
      idle(200);
      wr(0, 3);
      // R11: unmapped addresses change nothing
      phase = "R11";
      wr(12, 'hfff); wr(13, 'h3); wr(14, 'h7f); wr(15, 'h2);
      idle(300);
      // R2: stop, change geometry while stopped, restart
      phase = "R2";
      wr(0, 0);
      idle(20);
      wr(1, 7); wr(3, 2); wr(4, 3); wr(9, 7);
      idle(5);
      wr(0, 3);
      idle(300);
      // R1: reset in mid-run
      phase = "R1";
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(5);
      finish_run();
   end
endmodule